// File: doc/BRIEF.md
# Shared Timer Lock Bank

This block holds one lock flag for each function that shares a common timer resource. Any function takes its lock by reading its own lock register. The read returns the flag as it was just before the read and sets it in the same step. A reader that gets back a clear flag now owns the timer. A reader that gets back a set flag knows another function holds it, and its read leaves the flag unchanged. The owner gives the lock back by writing its register with any value.

Several requesters share the bank. Each one has its own register port: a read strobe, a write strobe and a byte address. The lock for function `k` sits at `BASE_ADDR + k * STRIDE`. Requests that reach the same lock in one cycle are resolved in a fixed order, so the outcome is always defined. All writes of the cycle take effect first. The reads then follow in order of requester index, lowest first. Read data comes back one cycle after the read strobe.

Top module: `sema_bank`

## Requirements
- R1: After a synchronous active-low reset, every lock is free, so the first read of any lock returns 0 in the busy bit.
- R2: A read of a free lock returns 0 in the busy bit (bit 0 of the read data) and leaves the lock held.
- R3: A read of a held lock returns 1 in the busy bit, and the lock stays held.
- R4: A write of any data value to a lock's address frees that lock.
- R5: Lock `k` is decoded at byte address `BASE_ADDR + k*STRIDE` (defaults 0x0100 and 4, with 8 locks). An address below the base, one not on a stride boundary, or one at or beyond lock count times stride selects no lock. A read of such an address returns all-zero data, and neither a read nor a write there changes any lock.
- R6: An access to one lock never changes any other lock.
- R7: When several requesters read the same lock in one cycle, they are resolved in ascending requester index. At most one of them, the lowest-indexed one, can see the lock free. The rest see it held.
- R8: When a write and a read reach the same lock in one cycle, the write is applied first. The read therefore sees the lock free and takes it.
- R9: Read data bits other than the busy bit are always 0. In a cycle with no read, the read data is all zero.
- R10: `req_rvalid[r]` is high in exactly the cycle after `req_rd[r]` was high. The matching data appears in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_rd | input | NUM_REQ | Per-requester read strobe (read and take) |
| req_wr | input | NUM_REQ | Per-requester write strobe (release) |
| req_addr | input | NUM_REQ*ADDR_W | Per-requester byte address, requester r at bits [r*ADDR_W +: ADDR_W] |
| req_rvalid | output | NUM_REQ | Per-requester read-data valid, one cycle after the read |
| req_rdata | output | NUM_REQ*DATA_W | Per-requester read data, busy bit at BUSY_BIT |

## Verification
A lock flag that holds the wrong value can only be seen when a later read returns a busy bit that is wrong. Each read therefore exposes the state one cycle after it is issued. A lost release shows up as a false 1 on the next read of that lock. A lost set shows up as a second requester winning a lock that is already held. The reference model follows every read and write in order, compares every requester's response on every clock, and so catches a wrong flag at the first read of that lock after the error.

// File: rtl/sema_pkg.sv
// Package: shared defaults for the lock bank.
// Assumes the stride is a power of two, so the decode reduces to shifts and masks.
package sema_pkg;
    localparam int SEMA_NUM_FN_DEF  = 8;
    localparam int SEMA_NUM_REQ_DEF = 2;
    localparam int SEMA_ADDR_W_DEF  = 16;
    localparam int SEMA_DATA_W_DEF  = 32;
    localparam int SEMA_BASE_DEF    = 32'h0100;
    localparam int SEMA_STRIDE_DEF  = 4;
    localparam int SEMA_BUSY_BIT    = 0;
endpackage

// File: rtl/sema_decode.sv
// Module: maps one requester's byte address to a lock index.
// Assumes STRIDE is a power of two and BASE_ADDR is aligned to it.
module sema_decode #(
    parameter int                NUM_FN    = 8,
    parameter int                ADDR_W    = 16,
    parameter int                STRIDE    = 4,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0100,
    parameter int                IDX_W     = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] slot_num;
    logic              unused_hi;

    // Offset from base, slot number and in-range test.
    always_comb begin
        offset    = addr - BASE_ADDR;
        slot_num  = offset / ADDR_W'(STRIDE);
        hit       = (addr >= BASE_ADDR) &&
                    ((offset % ADDR_W'(STRIDE)) == '0) &&
                    (slot_num < ADDR_W'(NUM_FN));
        idx       = slot_num[IDX_W-1:0];
        unused_hi = ^slot_num;
    end
endmodule

// File: rtl/sema_slot.sv
// Module: resolves one lock's same-cycle accesses.
// Writes apply first. Reads then follow in ascending requester order, and
// each reader sees the flag as the lower-indexed readers left it.
module sema_slot #(
    parameter int NUM_REQ = 2
) (
    input  logic               busy_q,
    input  logic [NUM_REQ-1:0] rd_sel,
    input  logic [NUM_REQ-1:0] wr_sel,
    output logic [NUM_REQ-1:0] grant,
    output logic [NUM_REQ-1:0] seen,
    output logic               busy_d
);
    logic taken;

    // Walk the readers in priority order over the post-write flag.
    always_comb begin
        taken = busy_q & ~(|wr_sel);
        for (int i = 0; i < NUM_REQ; i++) begin
            seen[i]  = taken;
            grant[i] = rd_sel[i] & ~taken;
            taken    = taken | rd_sel[i];
        end
        busy_d = taken;
    end
endmodule

// File: rtl/sema_bank.sv
// Module: bank of read-to-take lock flags, one per function, shared by
// NUM_REQ register ports. A read returns the prior flag and sets it. A write frees it.
// Assumes at most one owner per lock by protocol; the bank does not check who writes.
module sema_bank
    import sema_pkg::*;
#(
    parameter int                NUM_FN    = SEMA_NUM_FN_DEF,
    parameter int                NUM_REQ   = SEMA_NUM_REQ_DEF,
    parameter int                ADDR_W    = SEMA_ADDR_W_DEF,
    parameter int                DATA_W    = SEMA_DATA_W_DEF,
    parameter int                STRIDE    = SEMA_STRIDE_DEF,
    parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(SEMA_BASE_DEF),
    parameter int                BUSY_BIT  = SEMA_BUSY_BIT
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REQ-1:0]        req_rd,
    input  logic [NUM_REQ-1:0]        req_wr,
    input  logic [NUM_REQ*ADDR_W-1:0] req_addr,
    output logic [NUM_REQ-1:0]        req_rvalid,
    output logic [NUM_REQ*DATA_W-1:0] req_rdata
);
    localparam int IDX_W = (NUM_FN > 1) ? $clog2(NUM_FN) : 1;

    logic [NUM_REQ-1:0]                hit;
    logic [NUM_REQ-1:0][IDX_W-1:0]     idx;
    logic [NUM_FN-1:0][NUM_REQ-1:0]    rd_sel;
    logic [NUM_FN-1:0][NUM_REQ-1:0]    wr_sel;
    logic [NUM_FN-1:0][NUM_REQ-1:0]    grant;
    logic [NUM_FN-1:0][NUM_REQ-1:0]    seen;
    logic [NUM_FN-1:0]                 busy_q;
    logic [NUM_FN-1:0]                 busy_d;
    logic [NUM_REQ-1:0]                ret_bit;

    genvar r, f;
    generate
        for (r = 0; r < NUM_REQ; r++) begin : g_dec
            sema_decode #(
                .NUM_FN(NUM_FN), .ADDR_W(ADDR_W), .STRIDE(STRIDE),
                .BASE_ADDR(BASE_ADDR), .IDX_W(IDX_W)
            ) u_dec (
                .addr(req_addr[r*ADDR_W +: ADDR_W]),
                .hit (hit[r]),
                .idx (idx[r])
            );
        end
        for (f = 0; f < NUM_FN; f++) begin : g_slot
            for (r = 0; r < NUM_REQ; r++) begin : g_sel
                // Route requester r's strobes to lock f when its address selects f.
                assign rd_sel[f][r] = req_rd[r] & hit[r] & (idx[r] == IDX_W'(f));
                assign wr_sel[f][r] = req_wr[r] & hit[r] & (idx[r] == IDX_W'(f));
            end
            sema_slot #(.NUM_REQ(NUM_REQ)) u_slot (
                .busy_q(busy_q[f]),
                .rd_sel(rd_sel[f]),
                .wr_sel(wr_sel[f]),
                .grant (grant[f]),
                .seen  (seen[f]),
                .busy_d(busy_d[f])
            );
        end
    endgenerate

    // Gather the flag value each requester's read observed.
    always_comb begin
        for (int i = 0; i < NUM_REQ; i++) begin
            ret_bit[i] = 1'b0;
            for (int j = 0; j < NUM_FN; j++) begin
                ret_bit[i] = ret_bit[i] | (rd_sel[j][i] & seen[j][i]);
            end
        end
    end

    // Lock flags: cleared by reset, otherwise take the resolved next state.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= busy_d;
    end

    // Response registers: valid and data one cycle after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_rvalid <= '0;
            req_rdata  <= '0;
        end else begin
            req_rvalid <= req_rd;
            for (int i = 0; i < NUM_REQ; i++) begin
                req_rdata[i*DATA_W +: DATA_W] <= DATA_W'(ret_bit[i]) << BUSY_BIT;
            end
        end
    end
endmodule

// File: rtl/sema_bank_chk.sv
// Checker: temporal properties of the lock bank, bound to every instance.
module sema_bank_chk #(
    parameter int NUM_FN   = 8,
    parameter int NUM_REQ  = 2,
    parameter int DATA_W   = 32,
    parameter int BUSY_BIT = 0
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_REQ-1:0]             req_rd,
    input logic [NUM_REQ-1:0]             req_rvalid,
    input logic [NUM_REQ*DATA_W-1:0]      req_rdata,
    input logic [NUM_FN-1:0]              busy_q,
    input logic [NUM_FN-1:0][NUM_REQ-1:0] grant,
    input logic [NUM_FN-1:0][NUM_REQ-1:0] rd_sel,
    input logic [NUM_FN-1:0][NUM_REQ-1:0] wr_sel
);
    localparam logic [DATA_W-1:0] BUSY_MASK = DATA_W'(1) << BUSY_BIT;

    AST_RESET_FREES: assert property (@(posedge clk) !rst_n |=> busy_q == '0); // R1

    genvar f, r;
    generate
        for (f = 0; f < NUM_FN; f++) begin : g_f
            AST_TAKE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
                (|grant[f]) |=> busy_q[f]); // R2
            AST_HELD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
                (busy_q[f] && !(|wr_sel[f])) |=> busy_q[f]); // R3
            AST_WRITE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
                ((|wr_sel[f]) && !(|rd_sel[f])) |=> !busy_q[f]); // R4
            AST_FREE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
                (!busy_q[f] && !(|rd_sel[f])) |=> !busy_q[f]); // R6
            AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(grant[f])); // R7
        end
        for (r = 0; r < NUM_REQ; r++) begin : g_r
            AST_ONLY_BUSY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
                (req_rdata[r*DATA_W +: DATA_W] & ~BUSY_MASK) == '0); // R9
            AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
                req_rd[r] |=> req_rvalid[r]); // R10
            AST_NO_RVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                !req_rd[r] |=> !req_rvalid[r]); // R10
        end
    endgenerate
endmodule

bind sema_bank sema_bank_chk #(
    .NUM_FN(NUM_FN), .NUM_REQ(NUM_REQ), .DATA_W(DATA_W), .BUSY_BIT(BUSY_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_rvalid(req_rvalid),
    .req_rdata(req_rdata), .busy_q(busy_q), .grant(grant),
    .rd_sel(rd_sel), .wr_sel(wr_sel)
);

// File: tb/sim_sema_bank.sv
`timescale 1ns/1ps
module sim_sema_bank;
    localparam int NF = 8;
    localparam int NR = 2;
    localparam int AW = 16;
    localparam int DW = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NR-1:0]     rd = '0;
    logic [NR-1:0]     wr = '0;
    logic [NR*AW-1:0]  addr = '0;
    logic [NR-1:0]     rvalid;
    logic [NR*DW-1:0]  rdata;

    int checks = 0;
    int fails  = 0;
    int mbusy[NF];
    logic        exp_v[NR];
    logic [DW-1:0] exp_d[NR];

    always #2.5 clk = ~clk;

    sema_bank u0 (
        .clk(clk), .rst_n(rst_n), .req_rd(rd), .req_wr(wr),
        .req_addr(addr), .req_rvalid(rvalid), .req_rdata(rdata)
    );

    function automatic int slot_of(input logic [AW-1:0] a);
        int off;
        if (a < 16'h0100) return -1;
        off = int'(a) - 32'h0100;
        if (off % 4 != 0) return -1;
        if (off / 4 >= NF) return -1;
        return off / 4;
    endfunction

    task automatic put(input int r, input logic do_rd, input logic do_wr, input logic [AW-1:0] a);
        rd[r] = do_rd;
        wr[r] = do_wr;
        addr[r*AW +: AW] = a;
    endtask

    // One clock: predict, advance, compare at the falling edge, then idle the inputs.
    task automatic cycle(input string tag);
        int s;
        if (!rst_n) begin
            for (int k = 0; k < NF; k++) mbusy[k] = 0;
            for (int r = 0; r < NR; r++) begin exp_v[r] = 1'b0; exp_d[r] = '0; end
        end else begin
            for (int r = 0; r < NR; r++) if (wr[r]) begin
                s = slot_of(addr[r*AW +: AW]);
                if (s >= 0) mbusy[s] = 0;
            end
            for (int r = 0; r < NR; r++) begin
                exp_v[r] = rd[r];
                exp_d[r] = '0;
                if (rd[r]) begin
                    s = slot_of(addr[r*AW +: AW]);
                    if (s >= 0) begin
                        exp_d[r] = DW'(mbusy[s]);
                        mbusy[s] = 1;
                    end
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        for (int r = 0; r < NR; r++) begin
            checks++;
            if (rvalid[r] !== exp_v[r]) begin
                fails++;
                $display("FAIL %s R10 req%0d rvalid actual=%0b expected=%0b", tag, r, rvalid[r], exp_v[r]);
            end
            checks++;
            if (rdata[r*DW +: DW] !== exp_d[r]) begin
                fails++;
                $display("FAIL %s req%0d rdata actual=%h expected=%h", tag, r, rdata[r*DW +: DW], exp_d[r]);
            end
        end
        rd = '0;
        wr = '0;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) cycle("R1 reset");
        rst_n = 1'b1;
        cycle("R1 idle");
        // R1/R2: each lock is free after reset and is taken by the read
        for (int k = 0; k < NF; k++) begin
            put(0, 1, 0, 16'(16'h0100 + 4*k));
            cycle("R1 R2 first read");
        end
        // R3: a held lock reads back 1 from both requesters
        put(1, 1, 0, 16'h010C); cycle("R3 held req1");
        put(0, 1, 0, 16'h010C); cycle("R3 held req0");
        // R4: a release with any data value, then the lock can be taken again
        put(0, 0, 1, 16'h010C); cycle("R4 release");
        put(1, 1, 0, 16'h010C); cycle("R4 retake");
        put(1, 0, 1, 16'h010C); cycle("R4 release again");
        put(0, 1, 0, 16'h010C); cycle("R4 retake again");
        // R6: lock 5 is untouched by the lock 3 traffic
        put(1, 1, 0, 16'h0114); cycle("R6 neighbour held");
        // Free every lock
        for (int k = 0; k < NF; k++) begin
            put(0, 0, 1, 16'(16'h0100 + 4*k));
            cycle("R4 free all");
        end
        // R5: misses have no side effect
        put(0, 1, 0, 16'h0101); cycle("R5 misaligned read");
        put(1, 1, 0, 16'h0120); cycle("R5 past end read");
        put(0, 1, 0, 16'h00FC); cycle("R5 below base read");
        put(0, 1, 0, 16'h0100); cycle("R5 lock0 still free");
        put(1, 1, 0, 16'h0104); cycle("R5 take lock1");
        put(0, 0, 1, 16'h0105); cycle("R5 misaligned write");
        put(0, 1, 0, 16'h0104); cycle("R5 lock1 still held");
        // R7: same-cycle reads, the lower index wins
        put(0, 1, 0, 16'h0118); put(1, 1, 0, 16'h0118); cycle("R7 race free lock");
        put(0, 1, 0, 16'h0118); put(1, 1, 0, 16'h0118); cycle("R7 race held lock");
        // R8: a write and a read in one cycle, the write applies first
        put(0, 0, 1, 16'h0118); put(1, 1, 0, 16'h0118); cycle("R8 release and take");
        put(0, 1, 0, 16'h0118); cycle("R8 taken after");
        put(1, 1, 0, 16'h011C); put(0, 0, 1, 16'h011C); cycle("R8 free lock write+read");
        // R9/R10: random mixed traffic against the model
        for (int n = 0; n < 400; n++) begin
            for (int r = 0; r < NR; r++) begin
                logic [AW-1:0] a;
                a = ($urandom % 8 == 0) ? AW'($urandom % 16'h0130)
                                        : AW'(16'h0100 + 4 * ($urandom % NF));
                put(r, 1'($urandom % 2), 1'($urandom % 3 == 0), a);
            end
            cycle("R9 R10 random");
        end
        // R1: reset again mid-use frees every lock
        rst_n = 1'b0; cycle("R1 second reset");
        rst_n = 1'b1;
        put(0, 1, 0, 16'h0118); put(1, 1, 0, 16'h0104); cycle("R1 free after reset");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule